// File: doc/BRIEF.md
# Two-Level Address Translation Controller

The controller turns a 32-bit virtual address into a 32-bit physical address. A page is 64 KB, so the upper 16 bits of an address are the page number and the lower 16 bits are the offset. The offset passes through unchanged.

Each accepted request is first looked up in a small fully associative first-level table. On a miss there, the request goes to a larger 4-way set-associative second-level table. A hit at the second level installs the translation in the first-level table and returns the physical address. A miss at both levels completes the request with an error. Page-table walks are not modelled.

A free-running stamp counter marks every lookup hit and every write. The replacement logic uses these stamps to find the least recently used entry. A stamp of zero marks an entry as locked. Test code can install entries in either table through the preload port, with or without the lock.

Top module: `xlat_ctrl`

## Requirements
- R1: After reset, `rsp_valid` and `busy` are low and both tables are empty, so the first request completes with `rsp_err` = 1.
- R2: A request that hits the first-level table is answered one cycle after it is accepted. `rsp_paddr` is the stored 16-bit physical page number in bits 31:16 and the request's bits 15:0 in bits 15:0. `rsp_l2` = 0 and `rsp_err` = 0.
- R3: A first-level miss is answered two cycles after acceptance. `busy` is high in the cycle between acceptance and the answer. A request that is held while `busy` is high is accepted at the first clock edge where `busy` is low, which is two edges after the earlier acceptance.
- R4: The second-level table uses virtual page bits 6:0 as the set index and bits 15:7 as the tag. Pages that share an index but differ in tag translate independently, and so do pages that share a tag but differ in index. A hit sets `rsp_l2` = 1.
- R5: After a second-level hit, a later request to the same page hits the first-level table (`rsp_l2` = 0).
- R6: A miss in both tables answers with `rsp_err` = 1, `rsp_paddr` = 0 and `rsp_l2` = 0, two cycles after acceptance.
- R7: When all 10 first-level entries are valid, a refill replaces the unlocked entry whose stamp is smallest. Stamps come from a counter that advances every clock, and a hit restamps the entry it hits.
- R8: An entry preloaded with `pl_lock` = 1 is never evicted, and a hit on it does not change its stamp. When every entry of a set is locked, a new page is not installed in that set. The stamp counter never holds zero.
- R9: A write, either a preload or a refill, whose page is already present updates that entry's physical page number in place.
- R10: When a second-level set holds 4 valid unlocked entries, writing a fifth page with the same index evicts the least recently stamped entry of that set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset; empties both tables |
| req_valid | input | 1 | Translation request; accepted when `busy` and `pl_valid` are low |
| req_vaddr | input | 32 | Virtual address to translate |
| busy | output | 1 | High while a second-level lookup is in progress |
| rsp_valid | output | 1 | One-cycle pulse marking a response |
| rsp_paddr | output | 32 | Physical address, or zero on error |
| rsp_l2 | output | 1 | Translation came from the second-level table |
| rsp_err | output | 1 | Page was found in neither table |
| pl_valid | input | 1 | Preload write strobe; ignored while `busy` is high |
| pl_l2 | input | 1 | Preload target: 0 for the first-level table, 1 for the second-level table |
| pl_vpn | input | 16 | Virtual page number to install |
| pl_ppn | input | 16 | Physical page number to install |
| pl_lock | input | 1 | Install with stamp zero (locked) |

## Verification
A first-level hit is due in the cycle after the accepting edge. Any path that reaches the second level is due one cycle later. The bench records the edge at which each request was actually accepted and stores the expected address, flags and due cycle in a scoreboard queue. The monitor samples `rsp_valid` on the falling clock edge and checks that each response arrives in exactly its due cycle. Preloads are issued only after the queue has drained, so a preload never collides with a walk in progress.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_WALK = 1'b1
   } xlat_state_e;

endpackage

// File: rtl/xlat_victim.sv
module xlat_victim #(
   parameter int WAYS    = 4,
   parameter int STAMP_W = 32,
   parameter int SEL_W   = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic [WAYS-1:0]    valid_i,
   input  logic [WAYS-1:0]    match_i,
   input  logic [STAMP_W-1:0] stamp_i [WAYS],
   output logic [SEL_W-1:0]   sel_o,
   output logic               ok_o
);

   logic               found;
   logic [STAMP_W-1:0] best;

   always_comb begin
      found = 1'b0;
      sel_o = '0;
      best  = '1;
      for (int i = 0; i < WAYS; i++) begin
         if (!found && match_i[i]) begin
            found = 1'b1;
            sel_o = SEL_W'(i);
         end
      end
      for (int i = 0; i < WAYS; i++) begin
         if (!found && !valid_i[i]) begin
            found = 1'b1;
            sel_o = SEL_W'(i);
         end
      end
      if (!found) begin
         for (int i = 0; i < WAYS; i++) begin
            if (stamp_i[i] != '0 && (!ok_any(found) || stamp_i[i] < best)) begin
               found = 1'b1;
               sel_o = SEL_W'(i);
               best  = stamp_i[i];
            end
         end
      end
      ok_o = found;
   end

   function automatic logic ok_any(input logic f);
      return f;
   endfunction

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb #(
   parameter int ENTRIES = 512,
   parameter int WAYS    = 4,
   parameter int VPN_W   = 16,
   parameter int PPN_W   = 16,
   parameter int STAMP_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lk_en,
   input  logic [VPN_W-1:0]   lk_vpn,
   input  logic [STAMP_W-1:0] lk_stamp,
   output logic               lk_hit,
   output logic [PPN_W-1:0]   lk_ppn,
   input  logic               wr_en,
   input  logic [VPN_W-1:0]   wr_vpn,
   input  logic [PPN_W-1:0]   wr_ppn,
   input  logic [STAMP_W-1:0] wr_stamp
);

   localparam int SETS   = ENTRIES / WAYS;
   localparam int IDX_W  = (SETS > 1) ? $clog2(SETS) : 1;
   localparam int TAG_W  = (SETS > 1) ? VPN_W - $clog2(SETS) : VPN_W;
   localparam int NSETS  = 1 << IDX_W;
   localparam int SEL_W  = (WAYS > 1) ? $clog2(WAYS) : 1;

   initial begin
      assert (ENTRIES % WAYS == 0 && (SETS == 1 || NSETS == SETS) && TAG_W > 0)
         else $error("xlat_tlb: entries must split into a power-of-two number of sets");
   end

   logic [WAYS-1:0]    vld_q [NSETS];
   logic [TAG_W-1:0]   tag_q [NSETS][WAYS];
   logic [PPN_W-1:0]   ppn_q [NSETS][WAYS];
   logic [STAMP_W-1:0] stm_q [NSETS][WAYS];

   logic [IDX_W-1:0] lk_idx, wr_idx;
   logic [TAG_W-1:0] lk_tag, wr_tag;

   generate
      if (SETS > 1) begin : g_setassoc
         assign lk_idx = lk_vpn[IDX_W-1:0];
         assign lk_tag = lk_vpn[VPN_W-1:IDX_W];
         assign wr_idx = wr_vpn[IDX_W-1:0];
         assign wr_tag = wr_vpn[VPN_W-1:IDX_W];
      end else begin : g_fullassoc
         assign lk_idx = '0;
         assign lk_tag = lk_vpn;
         assign wr_idx = '0;
         assign wr_tag = wr_vpn;
      end
   endgenerate

   // lookup side
   logic [WAYS-1:0]  lk_match;
   logic [SEL_W-1:0] lk_way;

   always_comb begin
      lk_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         lk_match[w] = vld_q[lk_idx][w] && (tag_q[lk_idx][w] == lk_tag);
      end
      for (int w = WAYS - 1; w >= 0; w--) begin
         if (lk_match[w]) lk_way = SEL_W'(w);
      end
   end

   assign lk_hit = |lk_match;
   assign lk_ppn = ppn_q[lk_idx][lk_way];

   // write side
   logic [WAYS-1:0]  wr_match;
   logic [SEL_W-1:0] wr_sel;
   logic             wr_ok;

   always_comb begin
      for (int w = 0; w < WAYS; w++) begin
         wr_match[w] = vld_q[wr_idx][w] && (tag_q[wr_idx][w] == wr_tag);
      end
   end

   xlat_victim #(
      .WAYS    (WAYS),
      .STAMP_W (STAMP_W),
      .SEL_W   (SEL_W)
   ) u_victim (
      .valid_i (vld_q[wr_idx]),
      .match_i (wr_match),
      .stamp_i (stm_q[wr_idx]),
      .sel_o   (wr_sel),
      .ok_o    (wr_ok)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < NSETS; s++) vld_q[s] <= '0;
      end else if (wr_en && wr_ok) begin
         vld_q[wr_idx][wr_sel] <= 1'b1;
         tag_q[wr_idx][wr_sel] <= wr_tag;
         ppn_q[wr_idx][wr_sel] <= wr_ppn;
         stm_q[wr_idx][wr_sel] <= wr_stamp;
      end else if (lk_en && lk_hit && stm_q[lk_idx][lk_way] != '0) begin
         stm_q[lk_idx][lk_way] <= lk_stamp;
      end
   end

   // R8
   evict_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_ok && !(|wr_match) && (&vld_q[wr_idx])) |-> (stm_q[wr_idx][wr_sel] != '0));

   // R4
   hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_en |-> $onehot0(lk_match));

   // R9
   update_in_place_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (|wr_match)) |-> (wr_ok && wr_match[wr_sel]));

endmodule

// File: rtl/xlat_ctrl.sv
module xlat_ctrl
   import xlat_pkg::*;
#(
   parameter int VA_W         = 32,
   parameter int PA_W         = 32,
   parameter int OFF_W        = 16,
   parameter int UTLB_ENTRIES = 10,
   parameter int L2_ENTRIES   = 512,
   parameter int L2_WAYS      = 4,
   parameter int STAMP_W      = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    req_valid,
   input  logic [VA_W-1:0]         req_vaddr,
   output logic                    busy,
   output logic                    rsp_valid,
   output logic [PA_W-1:0]         rsp_paddr,
   output logic                    rsp_l2,
   output logic                    rsp_err,
   input  logic                    pl_valid,
   input  logic                    pl_l2,
   input  logic [VA_W-OFF_W-1:0]   pl_vpn,
   input  logic [PA_W-OFF_W-1:0]   pl_ppn,
   input  logic                    pl_lock
);

   localparam int VPN_W = VA_W - OFF_W;
   localparam int PPN_W = PA_W - OFF_W;

   initial begin
      assert (VA_W > OFF_W && PA_W > OFF_W && STAMP_W >= 2)
         else $error("xlat_ctrl: address widths must exceed the offset width");
   end

   xlat_state_e        state_q;
   logic [VA_W-1:0]    vaddr_q;
   logic [STAMP_W-1:0] cnt_q, cnt_nxt;

   logic idle, accept, pl_take;
   assign idle    = (state_q == ST_IDLE);
   assign busy    = !idle;
   assign accept  = req_valid && idle && !pl_valid;
   assign pl_take = pl_valid && idle;

   assign cnt_nxt = (cnt_q == '1) ? STAMP_W'(1) : cnt_q + 1'b1;

   // first-level table
   logic               u_hit, u_wr_en;
   logic [PPN_W-1:0]   u_ppn, u_wr_ppn;
   logic [VPN_W-1:0]   u_wr_vpn;
   logic [STAMP_W-1:0] u_wr_stamp;

   // second-level table
   logic               l2_hit, l2_wr_en;
   logic [PPN_W-1:0]   l2_ppn;
   logic [STAMP_W-1:0] pl_stamp;

   assign pl_stamp   = pl_lock ? '0 : cnt_q;
   assign u_wr_en    = (busy && l2_hit) || (pl_take && !pl_l2);
   assign u_wr_vpn   = idle ? pl_vpn : vaddr_q[VA_W-1:OFF_W];
   assign u_wr_ppn   = idle ? pl_ppn : l2_ppn;
   assign u_wr_stamp = idle ? pl_stamp : cnt_q;
   assign l2_wr_en   = pl_take && pl_l2;

   xlat_tlb #(
      .ENTRIES (UTLB_ENTRIES),
      .WAYS    (UTLB_ENTRIES),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .STAMP_W (STAMP_W)
   ) u_micro (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (accept),
      .lk_vpn   (req_vaddr[VA_W-1:OFF_W]),
      .lk_stamp (cnt_q),
      .lk_hit   (u_hit),
      .lk_ppn   (u_ppn),
      .wr_en    (u_wr_en),
      .wr_vpn   (u_wr_vpn),
      .wr_ppn   (u_wr_ppn),
      .wr_stamp (u_wr_stamp)
   );

   xlat_tlb #(
      .ENTRIES (L2_ENTRIES),
      .WAYS    (L2_WAYS),
      .VPN_W   (VPN_W),
      .PPN_W   (PPN_W),
      .STAMP_W (STAMP_W)
   ) u_second (
      .clk      (clk),
      .rst_n    (rst_n),
      .lk_en    (busy),
      .lk_vpn   (vaddr_q[VA_W-1:OFF_W]),
      .lk_stamp (cnt_q),
      .lk_hit   (l2_hit),
      .lk_ppn   (l2_ppn),
      .wr_en    (l2_wr_en),
      .wr_vpn   (pl_vpn),
      .wr_ppn   (pl_ppn),
      .wr_stamp (pl_stamp)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         vaddr_q   <= '0;
         cnt_q     <= STAMP_W'(1);
         rsp_valid <= 1'b0;
         rsp_paddr <= '0;
         rsp_l2    <= 1'b0;
         rsp_err   <= 1'b0;
      end else begin
         cnt_q     <= cnt_nxt;
         rsp_valid <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  if (u_hit) begin
                     rsp_valid <= 1'b1;
                     rsp_paddr <= {u_ppn, req_vaddr[OFF_W-1:0]};
                     rsp_l2    <= 1'b0;
                     rsp_err   <= 1'b0;
                  end else begin
                     state_q <= ST_WALK;
                     vaddr_q <= req_vaddr;
                  end
               end
            end
            ST_WALK: begin
               rsp_valid <= 1'b1;
               rsp_l2    <= l2_hit;
               rsp_err   <= !l2_hit;
               rsp_paddr <= l2_hit ? {l2_ppn, vaddr_q[OFF_W-1:0]} : '0;
               state_q   <= ST_IDLE;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R2
   micro_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && u_hit) |=> (rsp_valid && !rsp_l2 && !rsp_err));

   // R3
   walk_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !u_hit) |=> (busy && !rsp_valid));

   // R3
   walk_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (rsp_valid && !busy));

   // R6
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_paddr == '0 && !rsp_l2));

   // R8
   stamp_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q != '0);

endmodule

// File: tb/tb_xlat_ctrl.sv
`timescale 1ns/1ps
module tb_xlat_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_vaddr = '0;
   logic        busy;
   logic        rsp_valid;
   logic [31:0] rsp_paddr;
   logic        rsp_l2;
   logic        rsp_err;
   logic        pl_valid = 1'b0;
   logic        pl_l2 = 1'b0;
   logic [15:0] pl_vpn = '0;
   logic [15:0] pl_ppn = '0;
   logic        pl_lock = 1'b0;

   always #2 clk = ~clk;

   xlat_ctrl dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_vaddr (req_vaddr),
      .busy      (busy),
      .rsp_valid (rsp_valid),
      .rsp_paddr (rsp_paddr),
      .rsp_l2    (rsp_l2),
      .rsp_err   (rsp_err),
      .pl_valid  (pl_valid),
      .pl_l2     (pl_l2),
      .pl_vpn    (pl_vpn),
      .pl_ppn    (pl_ppn),
      .pl_lock   (pl_lock)
   );

   typedef struct {
      logic [31:0] pa;
      logic        l2;
      logic        err;
      int          due;
      string       rq;
   } exp_t;

   exp_t sb[$];
   int   cyc = 0;
   int   n_vec = 0;
   int   n_bad = 0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", rq, act, exp);
      end
   endtask

   // monitor: pops scoreboard items as responses appear
   always @(negedge clk) begin
      if (rst_n && rsp_valid) begin
         if (sb.size() == 0) begin
            chk(1'b0, "R3 unexpected response", rsp_paddr, 32'hFFFF_FFFF);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_paddr == e.pa, e.rq, rsp_paddr, e.pa);
            chk({rsp_l2, rsp_err} == {e.l2, e.err}, e.rq, {30'd0, rsp_l2, rsp_err}, {30'd0, e.l2, e.err});
            chk(cyc == e.due, e.rq, cyc, e.due);
         end
      end
   end

   task automatic send(input logic [31:0] va, input logic [31:0] pa, input bit l2, input bit err,
                       input string rq, output int acc);
      bit b;
      exp_t e;
      @(negedge clk);
      req_valid = 1'b1;
      req_vaddr = va;
      forever begin
         b = busy;
         @(posedge clk);
         if (!b) break;
         @(negedge clk);
      end
      #1;
      acc   = cyc;
      e.pa  = pa;
      e.l2  = l2;
      e.err = err;
      e.due = acc + ((l2 || err) ? 1 : 0);
      e.rq  = rq;
      sb.push_back(e);
      req_valid = 1'b0;
   endtask

   task automatic drain();
      wait (sb.size() == 0);
      @(negedge clk);
      @(negedge clk);
   endtask

   task automatic preload(input bit to_l2, input logic [15:0] vpn, input logic [15:0] ppn, input bit lock);
      @(negedge clk);
      pl_valid = 1'b1;
      pl_l2    = to_l2;
      pl_vpn   = vpn;
      pl_ppn   = ppn;
      pl_lock  = lock;
      @(negedge clk);
      pl_valid = 1'b0;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      finish_run();
   end

   initial begin
      int a1, a2, t;

      // R1: reset state and empty tables
      do_reset();
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R1 rsp_valid after reset", {31'd0, rsp_valid}, 32'd0);
      chk(busy == 1'b0, "R1 busy after reset", {31'd0, busy}, 32'd0);
      send(32'h1234_5678, 32'h0, 1'b0, 1'b1, "R1 R6 empty tables miss", t);
      drain();

      // R3 R5: second-level hit, then refill
      preload(1'b1, 16'h1234, 16'hABCD, 1'b0);
      send(32'h1234_5678, 32'hABCD_5678, 1'b1, 1'b0, "R3 second-level hit", t);
      chk(busy == 1'b1, "R3 busy during walk", {31'd0, busy}, 32'd1);
      send(32'h1234_0001, 32'hABCD_0001, 1'b0, 1'b0, "R5 refilled page hits first level", t);
      drain();

      // R2: first-level hit from preload
      preload(1'b0, 16'h0042, 16'h0777, 1'b0);
      send(32'h0042_FFFF, 32'h0777_FFFF, 1'b0, 1'b0, "R2 first-level hit", t);
      drain();

      // R3: request held while busy
      preload(1'b1, 16'h2000, 16'h0BEE, 1'b0);
      preload(1'b1, 16'h2001, 16'h0BEF, 1'b0);
      send(32'h2000_0010, 32'h0BEE_0010, 1'b1, 1'b0, "R3 first walk", a1);
      send(32'h2001_0020, 32'h0BEF_0020, 1'b1, 1'b0, "R3 held walk", a2);
      chk(a2 == a1 + 2, "R3 held request acceptance edge", a2, a1 + 2);
      drain();

      // R4: set index and tag split
      do_reset();
      preload(1'b1, 16'h0085, 16'h1111, 1'b0);
      preload(1'b1, 16'h0105, 16'h2222, 1'b0);
      preload(1'b1, 16'h0086, 16'h3333, 1'b0);
      send(32'h0085_0001, 32'h1111_0001, 1'b1, 1'b0, "R4 index 5 tag 1", t);
      send(32'h0105_0002, 32'h2222_0002, 1'b1, 1'b0, "R4 index 5 tag 2", t);
      send(32'h0086_0003, 32'h3333_0003, 1'b1, 1'b0, "R4 index 6 tag 1", t);
      drain();

      // R9: overwrite in place
      preload(1'b0, 16'h0500, 16'h0011, 1'b0);
      preload(1'b0, 16'h0500, 16'h0022, 1'b0);
      send(32'h0500_1234, 32'h0022_1234, 1'b0, 1'b0, "R9 updated page number", t);
      drain();

      // R7: least recently used replacement in the first level
      do_reset();
      for (int k = 0; k < 10; k++) preload(1'b0, 16'h0100 + 16'(k), 16'h0A00 + 16'(k), 1'b0);
      send(32'h0100_0000, 32'h0A00_0000, 1'b0, 1'b0, "R7 restamp oldest", t);
      drain();
      preload(1'b1, 16'h0200, 16'h0B00, 1'b0);
      send(32'h0200_0004, 32'h0B00_0004, 1'b1, 1'b0, "R7 refill into full table", t);
      send(32'h0101_0000, 32'h0, 1'b0, 1'b1, "R7 least recent entry evicted", t);
      send(32'h0100_0008, 32'h0A00_0008, 1'b0, 1'b0, "R7 restamped entry kept", t);
      send(32'h0200_0000, 32'h0B00_0000, 1'b0, 1'b0, "R7 refilled entry present", t);
      send(32'h0102_0000, 32'h0A02_0000, 1'b0, 1'b0, "R7 other entry kept", t);
      drain();

      // R8: locked entries survive replacement
      do_reset();
      preload(1'b0, 16'h0300, 16'h0C00, 1'b1);
      for (int k = 1; k < 10; k++) preload(1'b0, 16'h0300 + 16'(k), 16'h0C00 + 16'(k), 1'b0);
      preload(1'b1, 16'h0400, 16'h0D00, 1'b0);
      send(32'h0400_0000, 32'h0D00_0000, 1'b1, 1'b0, "R8 refill with one lock", t);
      send(32'h0301_0000, 32'h0, 1'b0, 1'b1, "R8 oldest unlocked evicted", t);
      send(32'h0300_0000, 32'h0C00_0000, 1'b0, 1'b0, "R8 locked entry kept", t);
      drain();

      do_reset();
      for (int k = 0; k < 10; k++) preload(1'b0, 16'h0600 + 16'(k), 16'h0E10 + 16'(k), 1'b1);
      preload(1'b1, 16'h0700, 16'h0E00, 1'b0);
      send(32'h0700_0000, 32'h0E00_0000, 1'b1, 1'b0, "R8 all locked walk", t);
      send(32'h0700_0004, 32'h0E00_0004, 1'b1, 1'b0, "R8 all locked no install", t);
      send(32'h0600_0000, 32'h0E10_0000, 1'b0, 1'b0, "R8 locked hit", t);
      drain();

      // R10: second-level set replacement
      do_reset();
      for (int k = 1; k <= 5; k++) preload(1'b1, 16'h0009 | 16'(k << 7), 16'h0F00 + 16'(k), 1'b0);
      send(32'h0089_0000, 32'h0, 1'b0, 1'b1, "R10 oldest way evicted", t);
      send(32'h0289_0010, 32'h0F05_0010, 1'b1, 1'b0, "R10 newest way present", t);
      send(32'h0109_0020, 32'h0F02_0020, 1'b1, 1'b0, "R10 second way kept", t);
      drain();

      chk(sb.size() == 0, "R3 all responses received", sb.size(), 32'd0);
      finish_run();
   end

endmodule